// File: doc/BRIEF.md
# Operand Unit with Local Function Decoder

This block is the arithmetic and logic stage of a single-cycle integer datapath. It pairs a purely combinational ALU with the small decoder that turns a 2-bit operation class from the main control plus the 6-bit function field of a register-format instruction into a 4-bit control code. The ALU applies that code to two operands and drives a result word and a zero flag. The datapath feeds the zero flag to its equal-compare branch.

The control code is `{invert_a, invert_b, sel[1:0]}`. The 2-bit select picks bitwise AND (00), bitwise OR (01), sum (10) or signed less-than (11). Subtraction is addition with B inverted and a carry-in of one, and that carry-in is taken from the invert_b bit. The code is also brought out at a port, so that the decoder can be observed on its own.

Top module: `alu_decode_unit`

## Requirements
- R1: With alu_op = 00 the code is 0010 and result = opa + opb modulo 2^32, whatever funct holds.
- R2: With alu_op = 01 the code is 0110 and result = opa - opb modulo 2^32, whatever funct holds.
- R3: With alu_op = 10, funct 100000 gives code 0010 (sum), 100010 gives 0110 (difference), 100100 gives 0000 (opa AND opb), 100101 gives 0001 (opa OR opb) and 101010 gives 0111 (less-than).
- R4: With alu_op = 10 and any other funct the code is 0010 (sum). alu_op = 11 decodes exactly as alu_op = 10.
- R5: Code bit 3 inverts opa, bit 2 inverts opb and adds a carry-in of one, and bits 1:0 select AND (00), OR (01), sum (10) or less-than (11).
- R6: With code 0111 the result is 1 in bit 0 and 0 in all other bits when opa < opb as signed two's-complement values, and 0 otherwise. This holds also when opa - opb overflows.
- R7: zero is 1 exactly when all 32 result bits are 0. Under alu_op = 01 this makes zero equal to (opa == opb).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from main control |
| funct | input | 6 | Function field of a register-format instruction |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ctrl_code | output | 4 | Decoded control code {invert_a, invert_b, sel} |
| result | output | 32 | ALU result |
| zero | output | 1 | High when the result is all zeros |

## Verification
Every output is combinational, so ctrl_code, result and zero are all due in the same cycle as the inputs that produce them, with no register in between. The bench drives a new input set just after a falling clock edge and reads the outputs a short, fixed delay later, still well before the next rising edge, so each check sees settled values. The checker uses final deferred assertions, so it judges only settled values and never a transient inside a time step.

// File: rtl/alu_decode_unit.sv
module alu_decode_unit #(
  parameter int W = 32
) (
  input  logic [1:0]   alu_op,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [3:0]   ctrl_code,
  output logic [W-1:0] result,
  output logic         zero
);
  localparam logic [3:0] C_AND = 4'b0000;
  localparam logic [3:0] C_OR  = 4'b0001;
  localparam logic [3:0] C_ADD = 4'b0010;
  localparam logic [3:0] C_SUB = 4'b0110;
  localparam logic [3:0] C_SLT = 4'b0111;

  always_comb begin
    case (alu_op)
      2'b00:   ctrl_code = C_ADD;
      2'b01:   ctrl_code = C_SUB;
      default: begin
        case (funct)
          6'b100000: ctrl_code = C_ADD;
          6'b100010: ctrl_code = C_SUB;
          6'b100100: ctrl_code = C_AND;
          6'b100101: ctrl_code = C_OR;
          6'b101010: ctrl_code = C_SLT;
          default:   ctrl_code = C_ADD;
        endcase
      end
    endcase
  end

  logic         inv_a, inv_b;
  logic [1:0]   sel;
  logic [W-1:0] a_eff, b_eff, sum;
  logic         less;

  assign {inv_a, inv_b, sel} = ctrl_code;
  assign a_eff = inv_a ? ~opa : opa;
  assign b_eff = inv_b ? ~opb : opb;
  assign sum   = a_eff + b_eff + {{(W-1){1'b0}}, inv_b};

  assign less = (opa[W-1] != opb[W-1]) ? opa[W-1] : sum[W-1];

  always_comb begin
    case (sel)
      2'b00:   result = a_eff & b_eff;
      2'b01:   result = a_eff | b_eff;
      2'b10:   result = sum;
      default: result = {{(W-1){1'b0}}, less};
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/alu_decode_unit_chk.sv
module alu_decode_unit_chk #(
  parameter int W = 32
) (
  input logic [1:0]   alu_op,
  input logic [5:0]   funct,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   ctrl_code,
  input logic [W-1:0] result,
  input logic         zero
);
  always_comb begin
    if (alu_op == 2'b00) begin
      // R1
      r1_sum_class_chk: assert final (ctrl_code == 4'b0010 && result == W'(opa + opb));
    end
    if (alu_op == 2'b01) begin
      // R2
      r2_diff_class_chk: assert final (ctrl_code == 4'b0110 && result == W'(opa - opb));
      // R7
      r7_equal_flag_chk: assert final (zero == (opa == opb));
    end
    if (alu_op[1] && funct == 6'b100100) begin
      // R3
      r3_and_chk: assert final (ctrl_code == 4'b0000 && result == (opa & opb));
    end
    if (alu_op[1] && funct == 6'b000000) begin
      // R4
      r4_default_chk: assert final (ctrl_code == 4'b0010);
    end
    if (ctrl_code == 4'b0111) begin
      // R6
      r6_signed_less_chk: assert final (result == {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))});
    end
  end
endmodule

bind alu_decode_unit alu_decode_unit_chk #(.W(W)) chk_i (
  .alu_op(alu_op), .funct(funct), .opa(opa), .opb(opb),
  .ctrl_code(ctrl_code), .result(result), .zero(zero)
);

// File: tb/alu_decode_unit_tb_top.sv
`timescale 1ns/1ps
module alu_decode_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] opa, opb, result;
  logic [3:0]  ctrl_code;
  logic        zero;
  int total = 0;
  int bad = 0;

  alu_decode_unit dut_i (
    .alu_op(alu_op), .funct(funct), .opa(opa), .opb(opb),
    .ctrl_code(ctrl_code), .result(result), .zero(zero)
  );

  localparam int NV = 16;
  // {alu_op, funct, opa, opb, expected result, expected code, expected zero}
  localparam logic [108:0] VEC [NV] = '{
    {2'b00, 6'b101010, 32'd5,        32'd7,        32'd12,       4'b0010, 1'b0},
    {2'b00, 6'b100100, 32'hFFFFFFFF, 32'd1,        32'd0,        4'b0010, 1'b1},
    {2'b01, 6'b100000, 32'd10,       32'd3,        32'd7,        4'b0110, 1'b0},
    {2'b01, 6'b100101, 32'h00001234, 32'h00001234, 32'd0,        4'b0110, 1'b1},
    {2'b10, 6'b100000, 32'h80000000, 32'h80000000, 32'd0,        4'b0010, 1'b1},
    {2'b10, 6'b100010, 32'd3,        32'd5,        32'hFFFFFFFE, 4'b0110, 1'b0},
    {2'b10, 6'b100100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b0000, 1'b0},
    {2'b10, 6'b100101, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 4'b0001, 1'b0},
    {2'b10, 6'b101010, 32'hFFFFFFFF, 32'd1,        32'd1,        4'b0111, 1'b0},
    {2'b10, 6'b101010, 32'd1,        32'hFFFFFFFF, 32'd0,        4'b0111, 1'b1},
    {2'b10, 6'b101010, 32'h80000000, 32'd1,        32'd1,        4'b0111, 1'b0},
    {2'b10, 6'b101010, 32'h7FFFFFFF, 32'h80000000, 32'd0,        4'b0111, 1'b1},
    {2'b10, 6'b000000, 32'd2,        32'd3,        32'd5,        4'b0010, 1'b0},
    {2'b11, 6'b100010, 32'd9,        32'd4,        32'd5,        4'b0110, 1'b0},
    {2'b11, 6'b101010, 32'd2,        32'd3,        32'd1,        4'b0111, 1'b0},
    {2'b10, 6'b101010, 32'd7,        32'd7,        32'd0,        4'b0111, 1'b1}
  };
  localparam string TAGS [NV] = '{
    "R1", "R1/R7", "R2", "R2/R7", "R3/R7", "R3", "R3/R5", "R3/R5",
    "R6", "R6", "R6 overflow", "R6 overflow", "R4", "R4", "R4/R6", "R6/R7"
  };

  task automatic check(input string tag, input logic [31:0] er,
                       input logic [3:0] ec, input logic ez);
    total++;
    if (result !== er || ctrl_code !== ec || zero !== ez) begin
      bad++;
      $display("FAIL %s: got result=%h code=%b zero=%b, expected result=%h code=%b zero=%b",
               tag, result, ctrl_code, zero, er, ec, ez);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    alu_op = op; funct = fn; opa = a; opb = b;
    #1;
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    alu_op = 2'b00; funct = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(2'b00, 6'b000000, 32'd0, 32'd0);
    check("reset R1/R7", 32'd0, 4'b0010, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][108:107], VEC[i][106:101], VEC[i][100:69], VEC[i][68:37]);
      check(TAGS[i], VEC[i][36:5], VEC[i][4:1], VEC[i][0]);
    end

    // R1: funct ignored for every value under alu_op 00
    for (int f = 0; f < 64; f++) begin
      logic [31:0] a, b;
      a = 32'h1357_9BDF * (f + 1);
      b = 32'h0246_8ACE ^ (f << 7);
      apply(2'b00, f[5:0], a, b);
      check("R1 funct ignored", a + b, 4'b0010, (a + b) == 0);
    end

    // R2: funct ignored under alu_op 01
    for (int f = 0; f < 64; f += 5) begin
      logic [31:0] a, b;
      a = 32'hDEAD_0000 + f;
      b = 32'h0000_BEEF * f;
      apply(2'b01, f[5:0], a, b);
      check("R2 funct ignored", a - b, 4'b0110, a == b);
    end

    // R4: alu_op 11 mirrors 10 for an AND and an unknown funct
    apply(2'b11, 6'b100100, 32'h0FF0_0FF0, 32'h00FF_00FF);
    check("R4 op11 AND", 32'h00F0_00F0, 4'b0000, 1'b0);
    apply(2'b11, 6'b111111, 32'hFFFF_FFFF, 32'd1);
    check("R4 op11 unknown", 32'd0, 4'b0010, 1'b1);

    // R6: most negative against most positive
    apply(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R6 extremes", 32'd1, 4'b0111, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule